// File: doc/BRIEF.md
# Sector Page-Write Load Controller

This block is a synchronous model of the way a flash segment takes in a whole-sector write. The host moves two active-low strobes, a chip select and a write strobe, and drives an address and a data byte. Both strobes have to be low for a write pulse to exist. The byte address is taken at the moment the later of the two strobes falls. The data byte is taken at the moment the first of them rises. Accepted bytes are collected in a 512-byte sector buffer. No erase step is used: the first accepted byte opens a load phase for the sector it addresses.

The load phase stays open for as long as each new write pulse begins within a fixed window of cycles after the previous one ended. When the window runs out, the block enters a self-timed programming phase of fixed length and holds `busy` high. At the end of that phase the sector image becomes readable through a byte-wide read port. Each byte that was loaded shows its last written value. Each byte that was not loaded shows 8'hFF, the value chosen here to stand for indeterminate content. Write pulses shorter than a minimum length are filtered out. Within one load phase, a byte addressed to a different sector is dropped and sets a sticky error flag.

Top module: `sector_load_ctrl`

## Requirements
- R1: The address `addr[19:0]` is taken at the clock where both `ce_n` and `we_n` are first seen low, so it is the address present when the later strobe falls. `addr[19:9]` is the sector and `addr[8:0]` is the byte index; later address changes during the pulse are ignored.
- R2: The data byte is the value of `din` present when the first of `ce_n`/`we_n` rises; data changes after that rise are ignored.
- R3: A pulse in which both strobes are low for fewer than MIN_PULSE clock cycles has no effect. It neither starts a load phase nor stores a byte. A pulse of exactly MIN_PULSE cycles is accepted.
- R4: An accepted write while idle starts a load phase (`load_active` = 1) for its sector. A new accepted write that arrives fewer than WIN_CYC cycles after the previous pulse ended keeps the load phase open.
- R5: When no write pulse is in progress for WIN_CYC cycles after the last accepted byte, `load_active` falls and `busy` rises. `busy` then stays high for exactly PROG_CYC cycles and is never high together with `load_active`.
- R6: After programming, `rd_data` for a loaded byte index `rd_idx` returns the last value written to it in that load phase, and `prog_sector` gives the sector that was programmed.
- R7: After programming, every byte index not loaded in that load phase reads 8'hFF. This includes bytes left over from an earlier sector.
- R8: Write pulses that arrive while `busy` is high are ignored.
- R9: During a load phase, a write whose sector differs from the phase's sector is dropped and sets `sec_err`. `sec_err` stays set until reset.
- R10: After reset, `busy`, `load_active` and `sec_err` are 0, and every byte index reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Active-low chip select strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 20 | Sector (upper 11 bits) and byte index (lower 9 bits) |
| din | input | 8 | Write data byte |
| rd_idx | input | 9 | Byte index of the sector image to read |
| rd_data | output | 8 | Image byte at `rd_idx`, 8'hFF when not loaded |
| busy | output | 1 | Programming phase in progress |
| load_active | output | 1 | Load phase open |
| sec_err | output | 1 | Sticky sector-mismatch flag |
| prog_sector | output | 11 | Sector of the current or last load phase |

## Verification
The hardest case to reach from the ports is the skewed strobe pulse. In this pulse the address moves before the later strobe falls and again while both strobes are low, and the data moves between the first rising strobe and the second. The bench drives `ce_n` and `we_n` separately at chosen negative edges and changes `addr` and `din` in every stage. It then programs the sector and checks that only the byte at the address and with the data from the correct moments appears. Pulses of one cycle and of exactly MIN_PULSE cycles, a write placed just inside the window, and writes issued after `busy` rises cover the edges of the filter, of the window and of the busy lock.

// File: rtl/slc_pkg.sv
// Shared types for the sector page-write load controller.
package slc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_t;
endpackage

// File: rtl/slc_strobe.sv
// Strobe front end: registers the host strobes, address and data. It detects
// a write pulse as the span in which both strobes are low. It takes the
// address when the pulse begins and the data when it ends, and rejects pulses
// shorter than MIN_PULSE cycles.
// Assumes the host inputs are synchronous to clk.
module slc_strobe #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              strobe_on,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1) + 1;

    logic              ce_q, we_q, on_prev;
    logic [ADDR_W-1:0] addr_q, addr_lat;
    logic [DATA_W-1:0] din_q;
    logic [CNT_W-1:0]  pulse_cnt;

    // Input register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b1;
            we_q   <= 1'b1;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            ce_q   <= ce_n;
            we_q   <= we_n;
            addr_q <= addr;
            din_q  <= din;
        end
    end

    assign strobe_on = ~ce_q & ~we_q;

    // Pulse tracking: latch the address at the pulse start and count its length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_prev   <= 1'b0;
            addr_lat  <= '0;
            pulse_cnt <= '0;
        end else begin
            on_prev <= strobe_on;
            if (strobe_on && !on_prev) begin
                addr_lat  <= addr_q;
                pulse_cnt <= CNT_W'(1);
            end else if (strobe_on && pulse_cnt != '1) begin
                pulse_cnt <= pulse_cnt + CNT_W'(1);
            end
        end
    end

    // Write event at the pulse end, gated by the glitch filter.
    always_comb begin
        wr_evt  = !strobe_on && on_prev && (pulse_cnt >= CNT_W'(MIN_PULSE));
        wr_addr = addr_lat;
        wr_data = din_q;
    end

    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> !wr_evt); // R3
endmodule

// File: rtl/slc_seq.sv
// Phase sequencer: idle, load and programming. It opens a load phase on the
// first accepted byte and keeps it open while bytes keep arriving within
// WIN_CYC cycles. It then runs a PROG_CYC-cycle programming phase. It also
// flags and drops bytes for a foreign sector.
// Assumes wr_evt is a single-cycle pulse.
module slc_seq
    import slc_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int BYTE_W   = 9,
    parameter int WIN_CYC  = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe_on,
    input  logic                     wr_evt,
    input  logic [ADDR_W-1:0]        wr_addr,
    output logic                     buf_we,
    output logic                     buf_clr,
    output logic                     busy,
    output logic                     load_active,
    output logic                     sec_err,
    output logic [ADDR_W-BYTE_W-1:0] prog_sector
);
    localparam int SEC_W  = ADDR_W - BYTE_W;
    localparam int WIN_W  = $clog2(WIN_CYC + 1);
    localparam int PROG_W = $clog2(PROG_CYC + 1);

    phase_t            phase;
    logic [SEC_W-1:0]  sector_lat;
    logic [WIN_W-1:0]  win_cnt;
    logic [PROG_W-1:0] prog_cnt;
    logic              same_sec;

    // Buffer write decode: accept in idle, or in load for the same sector.
    always_comb begin
        same_sec = (wr_addr[ADDR_W-1:BYTE_W] == sector_lat);
        buf_we   = wr_evt && ((phase == PH_IDLE) || ((phase == PH_LOAD) && same_sec));
        buf_clr  = wr_evt && (phase == PH_IDLE);
    end

    // Phase register, window timer, programming timer and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            sector_lat <= '0;
            win_cnt    <= '0;
            prog_cnt   <= '0;
            sec_err    <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (wr_evt) begin
                        phase      <= PH_LOAD;
                        sector_lat <= wr_addr[ADDR_W-1:BYTE_W];
                        win_cnt    <= '0;
                    end
                end
                PH_LOAD: begin
                    if (wr_evt && same_sec) begin
                        win_cnt <= '0;
                    end else begin
                        if (wr_evt) sec_err <= 1'b1;
                        if (!strobe_on) begin
                            if (win_cnt == WIN_W'(WIN_CYC - 1)) begin
                                phase    <= PH_PROG;
                                prog_cnt <= '0;
                            end else begin
                                win_cnt <= win_cnt + WIN_W'(1);
                            end
                        end
                    end
                end
                PH_PROG: begin
                    if (prog_cnt == PROG_W'(PROG_CYC - 1)) phase <= PH_IDLE;
                    else prog_cnt <= prog_cnt + PROG_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy        = (phase == PH_PROG);
    assign load_active = (phase == PH_LOAD);
    assign prog_sector = sector_lat;

    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && load_active)); // R5
    AST_PROG_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load_active)); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sec_err |=> sec_err); // R9
    AST_SECTOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_active && $past(load_active)) |-> $stable(prog_sector)); // R9
endmodule

// File: rtl/slc_buf.sv
// Sector buffer: one byte per index plus a loaded bitmap. The clear request
// empties the bitmap in the same cycle as the first byte of a new load phase.
// Reads return 8'hFF where no byte was loaded.
// Assumes clr is only asserted together with we.
module slc_buf #(
    parameter int BYTE_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              clr,
    input  logic [BYTE_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << BYTE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  loaded;

    // Loaded bitmap: cleared on a new phase, marked on each stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n) loaded <= '0;
        else if (we) loaded <= (clr ? '0 : loaded) | (DEPTH'(1) << widx);
    end

    // Byte storage; its contents only matter where the bitmap is set.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // Read mux with the fill value for unloaded bytes.
    always_comb begin
        rd_data = loaded[rd_idx] ? mem[rd_idx] : '1;
    end

    AST_CLR_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> we); // R7
endmodule

// File: rtl/sector_load_ctrl.sv
// Top level of the sector page-write load controller. It ties the strobe
// front end, the phase sequencer and the sector buffer together.
// Assumes the host inputs are synchronous to clk; time limits are given in cycles.
module sector_load_ctrl #(
    parameter int SEC_W     = 11,
    parameter int BYTE_W    = 9,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 2,
    parameter int WIN_CYC   = 7500,
    parameter int PROG_CYC  = 500000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic [SEC_W+BYTE_W-1:0] addr,
    input  logic [DATA_W-1:0]       din,
    input  logic [BYTE_W-1:0]       rd_idx,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    busy,
    output logic                    load_active,
    output logic                    sec_err,
    output logic [SEC_W-1:0]        prog_sector
);
    localparam int ADDR_W = SEC_W + BYTE_W;

    logic              strobe_on, wr_evt, buf_we, buf_clr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    slc_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .strobe_on(strobe_on), .wr_evt(wr_evt), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    slc_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .strobe_on(strobe_on), .wr_evt(wr_evt), .wr_addr(wr_addr),
        .buf_we(buf_we), .buf_clr(buf_clr), .busy(busy), .load_active(load_active),
        .sec_err(sec_err), .prog_sector(prog_sector)
    );

    slc_buf #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .clr(buf_clr),
        .widx(wr_addr[BYTE_W-1:0]), .wdata(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );
endmodule

// File: tb/sector_load_ctrl_test.sv
module sector_load_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int MINP = 2;
    localparam int WIN  = 32;
    localparam int PROG = 64;

    typedef struct {
        int       idx;
        int       val;
        string    req;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        ce_n = 1, we_n = 1;
    logic [19:0] addr = '0;
    logic [7:0]  din = '0;
    logic [8:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic        busy, load_active, sec_err;
    logic [10:0] prog_sector;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    exp_t exp_q[$];

    sector_load_ctrl #(.MIN_PULSE(MINP), .WIN_CYC(WIN), .PROG_CYC(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
        .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .load_active(load_active),
        .sec_err(sec_err), .prog_sector(prog_sector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Driver side of the scoreboard: record an expected image byte.
    task automatic expect_byte(input int idx, input int val, input string req);
        exp_t e;
        e.idx = idx; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor side: pop each expected byte and compare it with the read port.
    task automatic monitor_drain();
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            @(negedge clk);
            rd_idx = 9'(e.idx);
            #1;
            check(rd_data == 8'(e.val), e.req, rd_data, e.val);
        end
    endtask

    // One write pulse with both strobes low for 'hold' clock edges.
    task automatic write_byte(input int sec, input int idx, input int data, input int hold);
        @(negedge clk);
        addr = {11'(sec), 9'(idx)};
        din  = 8'(data);
        ce_n = 0; we_n = 0;
        repeat (hold) @(negedge clk);
        ce_n = 1; we_n = 1;
        repeat (3) @(negedge clk);
    endtask

    // Wait for busy to rise; return how many cycles that took.
    task automatic wait_busy(output int lat);
        lat = 0;
        while (!busy && lat < 400) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // Wait for busy to fall; return how many cycles it was seen high.
    task automatic wait_idle(output int len);
        len = 0;
        while (busy && len < 400) begin
            @(negedge clk);
            len++;
        end
    endtask

    initial begin
        int lat, len;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        check(busy == 0, "R10 busy", busy, 0);
        check(load_active == 0, "R10 load_active", load_active, 0);
        check(sec_err == 0, "R10 sec_err", sec_err, 0);
        expect_byte(0, 8'hFF, "R10 reset image");
        expect_byte(300, 8'hFF, "R10 reset image");
        monitor_drain();

        // Test A: sector 5, window kept open, overwrite, exact-minimum pulse.
        write_byte(5, 0, 8'h10, 3);
        #1 check(load_active == 1, "R4 load opened", load_active, 1);
        write_byte(5, 1, 8'h21, MINP);
        write_byte(5, 2, 8'h32, 3);
        write_byte(5, 511, 8'hEE, 4);
        write_byte(5, 2, 8'h3C, 3);
        repeat (WIN - 8) @(negedge clk);
        #1 check(load_active == 1 && busy == 0, "R4 inside window", load_active, 1);
        write_byte(5, 3, 8'h43, 3);
        wait_busy(lat);
        check(lat >= WIN - 4 && lat <= WIN + 2, "R5 timeout latency", lat, WIN);
        #1 check(load_active == 0, "R5 load closed", load_active, 0);
        wait_idle(len);
        check(len == PROG, "R5 busy length", len, PROG);
        check(prog_sector == 11'd5, "R6 prog_sector", prog_sector, 5);
        expect_byte(0, 8'h10, "R6 byte0");
        expect_byte(1, 8'h21, "R3 min pulse accepted");
        expect_byte(2, 8'h3C, "R6 last write wins");
        expect_byte(511, 8'hEE, "R6 top byte");
        expect_byte(3, 8'h43, "R4 byte after long gap");
        expect_byte(4, 8'hFF, "R7 unloaded");
        expect_byte(100, 8'hFF, "R7 unloaded");
        monitor_drain();

        // Test B: glitch pulse while idle.
        write_byte(6, 9, 8'h99, 1);
        #1 check(load_active == 0, "R3 glitch no load", load_active, 0);
        repeat (WIN + 8) @(negedge clk);
        #1 check(busy == 0, "R3 glitch no program", busy, 0);
        expect_byte(0, 8'h10, "R3 image untouched");
        monitor_drain();

        // Test C: foreign sector during load, then writes during busy.
        write_byte(9, 10, 8'h11, 3);
        write_byte(10, 11, 8'h22, 3);
        #1 check(sec_err == 1, "R9 sec_err set", sec_err, 1);
        write_byte(9, 12, 8'h33, 3);
        wait_busy(lat);
        write_byte(9, 13, 8'h77, 3);
        write_byte(9, 10, 8'h55, 3);
        wait_idle(len);
        check(prog_sector == 11'd9, "R6 prog_sector", prog_sector, 9);
        #1 check(sec_err == 1, "R9 sec_err sticky", sec_err, 1);
        check(load_active == 0, "R8 no load from busy write", load_active, 0);
        expect_byte(10, 8'h11, "R8 busy write ignored");
        expect_byte(11, 8'hFF, "R9 foreign byte dropped");
        expect_byte(12, 8'h33, "R6 byte12");
        expect_byte(13, 8'hFF, "R8 busy write ignored");
        expect_byte(0, 8'hFF, "R7 old sector cleared");
        monitor_drain();

        // Test D: skewed strobes with moving address and data.
        @(negedge clk);
        addr = {11'd3, 9'd21}; din = 8'h00; ce_n = 0;
        repeat (3) @(negedge clk);
        addr = {11'd3, 9'd20}; din = 8'hA5; we_n = 0;
        repeat (3) @(negedge clk);
        addr = {11'd3, 9'd22};
        @(negedge clk);
        we_n = 1;
        @(negedge clk);
        din = 8'h5A;
        repeat (2) @(negedge clk);
        ce_n = 1;
        repeat (3) @(negedge clk);
        wait_busy(lat);
        wait_idle(len);
        check(prog_sector == 11'd3, "R1 sector from later fall", prog_sector, 3);
        expect_byte(20, 8'hA5, "R1 R2 skewed capture");
        expect_byte(21, 8'hFF, "R1 early address ignored");
        expect_byte(22, 8'hFF, "R1 late address ignored");
        monitor_drain();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R5 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule